// File: doc/BRIEF.md
# Packed Sample Extremum Tracker

This block scans a stream of data words for the largest and smallest signed sample, and for the position where each first appeared. Each word holds two signed 16-bit samples. A running sample counter numbers every sample that passes through. A new extreme value is stored together with the counter value at which it arrived. Software pulses a clear strobe before a loop, streams the array through the valid-qualified word input, and afterwards reads two packed result words and the counter. It uses the results for block floating point range finding: the extremes give the headroom of the whole block in one pass.

Each result word holds a value in its upper half and an index in its lower half. The maximum and the minimum are tracked side by side, so one word can move both of them.

Top module: `mmx_tracker`

## Requirements
- R1: After reset, and one clock after a clear strobe, the maximum result reads value -32768 (bits 31:16 = 0x8000) with index 0 (bits 15:0), the minimum result reads value +32767 (0x7FFF) with index 0, and the counter reads 0.
- R2: Within a word, the sample in bits 31:16 is evaluated before the sample in bits 15:0. The upper sample is tagged with the counter value as it stood before the word, and the lower sample with that value plus one.
- R3: The stored maximum is replaced only by a sample strictly greater than it. On equal values the earlier index is kept.
- R4: The stored minimum is replaced only by a sample strictly smaller than it. On equal values the earlier index is kept.
- R5: Each accepted word advances the counter by two, and the counter wraps modulo 65536.
- R6: Results and counter change on the clock edge that samples a valid word, and they hold their values in every cycle with no valid word and no clear.
- R7: When clear and valid fall in the same cycle, the clear wins: the word is discarded and not counted.
- R8: Maximum and minimum are updated in parallel, so a single word can change both results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear strobe: restarts the search |
| vld_i | input | 1 | Qualifies word_i |
| word_i | input | 32 | Two packed signed samples, upper evaluated first |
| max_o | output | 32 | Maximum value [31:16], its index [15:0] |
| min_o | output | 32 | Minimum value [31:16], its index [15:0] |
| idx_o | output | 16 | Running sample counter |

## Verification
The clear strobe and a valid word can arrive in the same cycle. The bench forces this by raising both strobes on one clock edge, with a word that would otherwise move both extremes. It then checks that the results read their cleared values and that the counter reads 0, not 2. A follow-up word must be tagged with indices 0 and 1, which shows that the discarded word left no trace.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
   typedef enum logic {DIR_MAX = 1'b0, DIR_MIN = 1'b1} mmx_dir_e;
endpackage

// File: rtl/mmx_lane_cmp.sv
module mmx_lane_cmp #(
   parameter int SW = 16,
   parameter int IW = 16,
   parameter mmx_pkg::mmx_dir_e DIR = mmx_pkg::DIR_MAX
) (
   input  logic signed [SW-1:0] best_val_i,
   input  logic        [IW-1:0] best_idx_i,
   input  logic signed [SW-1:0] smp_i,
   input  logic        [IW-1:0] smp_idx_i,
   output logic signed [SW-1:0] best_val_o,
   output logic        [IW-1:0] best_idx_o
);
   logic take;

   generate
      if (DIR == mmx_pkg::DIR_MAX) begin : g_max
         assign take = (smp_i > best_val_i);
      end else begin : g_min
         assign take = (smp_i < best_val_i);
      end
   endgenerate

   assign best_val_o = take ? smp_i     : best_val_i;
   assign best_idx_o = take ? smp_idx_i : best_idx_i;
endmodule

// File: rtl/mmx_chain.sv
module mmx_chain #(
   parameter int SW    = 16,
   parameter int IW    = 16,
   parameter int LANES = 2,
   parameter mmx_pkg::mmx_dir_e DIR = mmx_pkg::DIR_MAX
) (
   input  logic        [LANES*SW-1:0] word_i,
   input  logic        [IW-1:0]       base_idx_i,
   input  logic signed [SW-1:0]       best_val_i,
   input  logic        [IW-1:0]       best_idx_i,
   output logic signed [SW-1:0]       best_val_o,
   output logic        [IW-1:0]       best_idx_o
);
   logic signed [SW-1:0] val_c [LANES+1];
   logic        [IW-1:0] idx_c [LANES+1];

   assign val_c[0] = best_val_i;
   assign idx_c[0] = best_idx_i;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic signed [SW-1:0] smp;
         logic        [IW-1:0] sidx;
         assign smp  = word_i[(LANES-1-k)*SW +: SW];
         assign sidx = base_idx_i + IW'(k);
         mmx_lane_cmp #(.SW(SW), .IW(IW), .DIR(DIR)) u_cmp (
            .best_val_i (val_c[k]),
            .best_idx_i (idx_c[k]),
            .smp_i      (smp),
            .smp_idx_i  (sidx),
            .best_val_o (val_c[k+1]),
            .best_idx_o (idx_c[k+1])
         );
      end
   endgenerate

   assign best_val_o = val_c[LANES];
   assign best_idx_o = idx_c[LANES];
endmodule

// File: rtl/mmx_idx_ctr.sv
module mmx_idx_ctr #(
   parameter int IW    = 16,
   parameter int LANES = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          adv_i,
   output logic [IW-1:0] cnt_o
);
   localparam logic [IW-1:0] STEP = IW'(LANES);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) cnt_o <= '0;
      else if (adv_i)       cnt_o <= cnt_o + STEP;
   end
endmodule

// File: rtl/mmx_tracker.sv
module mmx_tracker #(
   parameter int SAMPLE_W = 16,
   parameter int IDX_W    = 16,
   parameter int LANES    = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        clr_i,
   input  logic                        vld_i,
   input  logic [LANES*SAMPLE_W-1:0]   word_i,
   output logic [SAMPLE_W+IDX_W-1:0]   max_o,
   output logic [SAMPLE_W+IDX_W-1:0]   min_o,
   output logic [IDX_W-1:0]            idx_o
);
   localparam logic signed [SAMPLE_W-1:0] NEG_LIM = {1'b1, {(SAMPLE_W-1){1'b0}}};
   localparam logic signed [SAMPLE_W-1:0] POS_LIM = {1'b0, {(SAMPLE_W-1){1'b1}}};

   generate
      if (SAMPLE_W < 2) begin : g_bad_sw
         $error("mmx_tracker: SAMPLE_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("mmx_tracker: LANES must be at least 1");
      end
      if ((1 << IDX_W) < LANES) begin : g_bad_iw
         $error("mmx_tracker: IDX_W too narrow for LANES");
      end
   endgenerate

   logic signed [SAMPLE_W-1:0] max_val_q, min_val_q, max_val_d, min_val_d;
   logic        [IDX_W-1:0]    max_idx_q, min_idx_q, max_idx_d, min_idx_d;
   logic        [IDX_W-1:0]    cnt;
   logic                       accept;

   assign accept = vld_i && !clr_i;

   mmx_idx_ctr #(.IW(IDX_W), .LANES(LANES)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .adv_i  (accept),
      .cnt_o  (cnt)
   );

   mmx_chain #(.SW(SAMPLE_W), .IW(IDX_W), .LANES(LANES), .DIR(mmx_pkg::DIR_MAX)) u_max (
      .word_i     (word_i),
      .base_idx_i (cnt),
      .best_val_i (max_val_q),
      .best_idx_i (max_idx_q),
      .best_val_o (max_val_d),
      .best_idx_o (max_idx_d)
   );

   mmx_chain #(.SW(SAMPLE_W), .IW(IDX_W), .LANES(LANES), .DIR(mmx_pkg::DIR_MIN)) u_min (
      .word_i     (word_i),
      .base_idx_i (cnt),
      .best_val_i (min_val_q),
      .best_idx_i (min_idx_q),
      .best_val_o (min_val_d),
      .best_idx_o (min_idx_d)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         max_val_q <= NEG_LIM;
         max_idx_q <= '0;
         min_val_q <= POS_LIM;
         min_idx_q <= '0;
      end else if (accept) begin
         max_val_q <= max_val_d;
         max_idx_q <= max_idx_d;
         min_val_q <= min_val_d;
         min_idx_q <= min_idx_d;
      end
   end

   assign max_o = {max_val_q, max_idx_q};
   assign min_o = {min_val_q, min_idx_q};
   assign idx_o = cnt;
endmodule

// File: rtl/mmx_tracker_chk.sv
module mmx_tracker_chk #(
   parameter int SW    = 16,
   parameter int IW    = 16,
   parameter int LANES = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clr_i,
   input logic             vld_i,
   input logic [SW+IW-1:0] max_o,
   input logic [SW+IW-1:0] min_o,
   input logic [IW-1:0]    idx_o
);
   localparam logic [SW-1:0] NEG_LIM = {1'b1, {(SW-1){1'b0}}};
   localparam logic [SW-1:0] POS_LIM = {1'b0, {(SW-1){1'b1}}};

   AST_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (max_o == {NEG_LIM, {IW{1'b0}}}) && (min_o == {POS_LIM, {IW{1'b0}}}) && (idx_o == '0)); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !vld_i) |=> $stable(max_o) && $stable(min_o) && $stable(idx_o)); // R6

   AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !clr_i) |=> idx_o == $past(idx_o) + IW'(LANES)); // R5

   AST_MAX_NONDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !clr_i) |=> $signed(max_o[SW+IW-1:IW]) >= $signed($past(max_o[SW+IW-1:IW]))); // R3

   AST_MIN_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !clr_i) |=> $signed(min_o[SW+IW-1:IW]) <= $signed($past(min_o[SW+IW-1:IW]))); // R4

   AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && clr_i) |=> idx_o == '0); // R7
endmodule

bind mmx_tracker mmx_tracker_chk #(.SW(SAMPLE_W), .IW(IDX_W), .LANES(LANES)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .clr_i  (clr_i),
   .vld_i  (vld_i),
   .max_o  (max_o),
   .min_o  (min_o),
   .idx_o  (idx_o)
);

// File: tb/mmx_tracker_bench.sv
`timescale 1ns/1ps
module mmx_tracker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        vld = 1'b0;
   logic [31:0] word = '0;
   logic [31:0] max_w, min_w;
   logic [15:0] idx_w;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic signed [15:0] m_max, m_min;
   logic        [15:0] m_maxi, m_mini, m_cnt;

   always #10 clk = ~clk;

   mmx_tracker u_mmx_tracker (
      .clk_i (clk), .rst_ni (rst_n), .clr_i (clr), .vld_i (vld),
      .word_i (word), .max_o (max_w), .min_o (min_w), .idx_o (idx_w)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      m_max = 16'sh8000; m_maxi = '0;
      m_min = 16'sh7FFF; m_mini = '0;
      m_cnt = '0;
   endtask

   task automatic model_word(input logic [31:0] w);
      for (int k = 0; k < 2; k++) begin
         logic signed [15:0] s;
         s = (k == 0) ? w[31:16] : w[15:0];
         if (s > m_max) begin m_max = s; m_maxi = m_cnt + 16'(k); end
         if (s < m_min) begin m_min = s; m_mini = m_cnt + 16'(k); end
      end
      m_cnt = m_cnt + 16'd2;
   endtask

   task automatic check_model(input string tag);
      chk({tag, " max"}, max_w, {m_max, m_maxi});
      chk({tag, " min"}, min_w, {m_min, m_mini});
      chk({tag, " idx"}, {16'h0, idx_w}, {16'h0, m_cnt});
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      model_clear();
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk); vld = 1'b1; word = w;
      @(negedge clk); vld = 1'b0;
      model_word(w);
   endtask

   task automatic t_reset();
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset max", max_w, 32'h8000_0000);
      chk("R1 reset min", min_w, 32'h7FFF_0000);
      chk("R1 reset idx", {16'h0, idx_w}, 32'h0);
      model_clear();
   endtask

   task automatic t_order_tie();
      do_clear();
      send({16'd5, 16'd5});
      chk("R2 upper first max tie", max_w, {16'd5, 16'd0});
      chk("R4 min tie keeps earlier", min_w, {16'd5, 16'd0});
      send({16'd5, 16'd5});
      chk("R3 max tie across words", max_w, {16'd5, 16'd0});
      chk("R5 idx after two words", {16'h0, idx_w}, 32'd4);
   endtask

   task automatic t_strict();
      do_clear();
      send({16'd10, 16'hFFFB});
      chk("R2 lower gets cnt+1", min_w, {16'hFFFB, 16'd1});
      chk("R3 max first", max_w, {16'd10, 16'd0});
      send({16'd10, 16'hFFFB});
      check_model("R3 R4 equal no update");
      send({16'd11, 16'hFFFA});
      chk("R3 strictly greater", max_w, {16'd11, 16'd4});
      chk("R4 strictly smaller", min_w, {16'hFFFA, 16'd5});
   endtask

   task automatic t_parallel();
      do_clear();
      send({16'hFFFD, 16'd9});
      chk("R8 max", max_w, {16'd9, 16'd1});
      chk("R8 min", min_w, {16'hFFFD, 16'd0});
   endtask

   task automatic t_stream();
      logic [31:0] lfsr = 32'hACE1_1234;
      do_clear();
      for (int n = 0; n < 60; n++) begin
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         send(lfsr);
         check_model("R2 R3 R4 stream");
      end
   endtask

   task automatic t_hold();
      logic [31:0] mx, mn;
      logic [15:0] ix;
      send({16'h7000, 16'h9000});
      mx = max_w; mn = min_w; ix = idx_w;
      @(negedge clk); word = {16'h7FFF, 16'h8000};
      repeat (5) @(negedge clk);
      chk("R6 hold max", max_w, mx);
      chk("R6 hold min", min_w, mn);
      chk("R6 hold idx", {16'h0, idx_w}, {16'h0, ix});
   endtask

   task automatic t_collide();
      send({16'd1, 16'd2});
      @(negedge clk); clr = 1'b1; vld = 1'b1; word = {16'd100, 16'hFF9C};
      @(negedge clk); clr = 1'b0; vld = 1'b0;
      model_clear();
      chk("R7 collide max", max_w, 32'h8000_0000);
      chk("R7 collide min", min_w, 32'h7FFF_0000);
      chk("R7 collide idx", {16'h0, idx_w}, 32'h0);
      send({16'd3, 16'hFFFD});
      chk("R7 next word max", max_w, {16'd3, 16'd0});
      chk("R7 next word min", min_w, {16'hFFFD, 16'd1});
   endtask

   task automatic t_wrap();
      do_clear();
      @(negedge clk); vld = 1'b1; word = 32'h0;
      repeat (32768) @(negedge clk);
      vld = 1'b0;
      chk("R5 wrap idx", {16'h0, idx_w}, 32'h0);
      chk("R5 wrap max", max_w, 32'h0);
      m_max = 16'sd0; m_maxi = 0; m_min = 16'sd0; m_mini = 0; m_cnt = 0;
      send({16'd7, 16'hFFF0});
      chk("R5 after wrap max", max_w, {16'd7, 16'd0});
      chk("R5 after wrap min", min_w, {16'hFFF0, 16'd1});
      chk("R5 after wrap idx", {16'h0, idx_w}, 32'd2);
   endtask

   initial begin
      t_reset();
      t_order_tie();
      t_strict();
      t_parallel();
      t_stream();
      t_hold();
      t_collide();
      t_wrap();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule